// File: doc/BRIEF.md
# Serial NAND Operation Flow Sequencer

This block turns one high-level request into the ordered list of command frames that a serial NAND device needs. The request can be a device reset, an identification read, a page read, a page program or a block erase. Each frame is handed to a byte serializer as a descriptor. The descriptor gives the opcode, the address and how many address bytes it uses, the dummy byte count, the data direction, the data length and whether data moves on four lanes. Whenever the device must finish an internal array operation, the block asks a status poller to wait for ready. The poller answers with the final status byte.

The multi-step flows depend on the device's split between array and cache. A page read moves the array into the cache and waits, then streams the cache out. A program first enables writes and fills the cache, then commits the cache to the array and waits. An erase enables writes, erases the row's block and waits. Only one request is in flight at a time. When it finishes, the block pulses a completion strobe with a pass/fail flag and, for reads, the on-die ECC outcome. Identification bytes returned by the serializer are collected into a register.

Top module: `nand_flow_seq`

## Requirements
- R1: After reset, busy, frm_valid, poll_req and done are all low.
- R2: A request is accepted when req_valid is high while busy is low. Busy is high from the next cycle until the completion strobe. req_valid pulses while busy have no effect: they start no frames and do not alter the latched request fields.
- R3: A reset request (req_kind 0) sends opcode 0xFF with no address, dummy or data, then makes one wait-ready request. It completes with fail low.
- R4: An ID request (req_kind 1) sends one 0x9F frame that reads 4 bytes on one lane, with no wait-ready. Form 0 has no address or dummy. Form 1 adds one address byte of value 0. Form 2 adds one dummy byte. Form 3 behaves as form 0.
- R5: During the ID frame, the k-th byte received on rx_valid is stored in id_data bits [8k+7:8k]. id_data is cleared when any request is accepted and changes only during an ID frame.
- R6: A page read (req_kind 2) sends 0x13 with the 3-byte row, waits for ready, then sends a cache read with the 2-byte column, one dummy byte and req_len bytes of input. The cache read uses 0x0B on one lane, or 0x6B on four lanes when req_quad is set.
- R7: A page read reports done_ecc equal to status bits [5:4], and fail is high exactly when they equal 2'b10. Every other request reports done_ecc of 0.
- R8: A program (req_kind 3) sends 0x06, then a cache load carrying the 2-byte column and req_len output bytes, then 0x10 with the 3-byte row, then waits for ready.
- R9: The cache-load opcode is 0x02 (one lane) or 0x32 (four lanes) when req_random_load is low. It is 0x84 or 0x34 when req_random_load is high. req_quad selects the four-lane form.
- R10: A program completes with fail equal to status bit 3, and status bit 2 has no effect on it.
- R11: An erase (req_kind 4) sends 0x06, then 0xD8 with the 3-byte row, then waits for ready. It completes with fail equal to status bit 2, and status bit 3 has no effect on it.
- R12: While frm_valid is high and frm_ready is low, the descriptor holds steady. The next frame or wait-ready request starts only after frm_done.
- R13: done is a one-cycle pulse, and busy is low in the cycle done is high.
- R14: A request with req_kind 5, 6 or 7 sends no frame and no wait-ready, and completes with fail high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_kind | input | 3 | 0 reset, 1 ID read, 2 page read, 3 program, 4 erase |
| req_row | input | 24 | Row (page/block) address |
| req_col | input | 16 | Column address inside the cache |
| req_len | input | LEN_W | Data byte count for cache read or load |
| req_random_load | input | 1 | Cache load keeps existing cache contents |
| req_quad | input | 1 | Cache data on four lanes |
| req_id_form | input | 2 | ID read form: 0 plain, 1 address byte, 2 dummy byte |
| busy | output | 1 | A request is in flight |
| frm_valid | output | 1 | Frame descriptor offered to the serializer |
| frm_ready | input | 1 | Serializer takes the descriptor |
| frm_opcode | output | 8 | Command byte |
| frm_addr | output | 24 | Address value, low bytes used |
| frm_addr_bytes | output | 2 | Number of address bytes (0 to 3) |
| frm_dummy_bytes | output | 2 | Number of dummy bytes |
| frm_dir | output | 2 | 0 no data, 1 data in, 2 data out |
| frm_quad | output | 1 | Data phase on four lanes |
| frm_len | output | LEN_W | Data byte count |
| frm_done | input | 1 | Serializer finished the accepted frame |
| rx_valid | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| poll_req | output | 1 | Wait-ready request to the poller |
| poll_done | input | 1 | Poller reports ready |
| poll_status | input | 8 | Final status byte with poll_done |
| done | output | 1 | Completion pulse |
| done_fail | output | 1 | Failure flag, valid with done |
| done_ecc | output | 2 | ECC outcome, valid with done |
| id_data | output | 8*ID_BYTES | Collected identification bytes |

## Verification
Two situations are hardest to produce at the ports. One is a serializer that holds off acceptance for several cycles while the descriptor must stay put. The other is a second request that arrives mid-flow with different fields. The bench serializer model can stall each frame by a programmable number of cycles, and one program run injects an erase request partway through, so the bench can check that the frame log contains only the program frames. The serializer also returns bytes on ordinary cache reads, which shows that the identification register does not pick them up.

// File: rtl/nand_flow_pkg.sv
package nand_flow_pkg;

    localparam int ROW_W = 24;
    localparam int COL_W = 16;

    localparam logic [7:0] OPC_RESET      = 8'hFF;
    localparam logic [7:0] OPC_WREN       = 8'h06;
    localparam logic [7:0] OPC_READ_ID    = 8'h9F;
    localparam logic [7:0] OPC_ARRAY_READ = 8'h13;
    localparam logic [7:0] OPC_CACHE_RD1  = 8'h0B;
    localparam logic [7:0] OPC_CACHE_RD4  = 8'h6B;
    localparam logic [7:0] OPC_EXECUTE    = 8'h10;
    localparam logic [7:0] OPC_ERASE      = 8'hD8;
    localparam logic [7:0] OPC_LOAD1_CLR  = 8'h02;
    localparam logic [7:0] OPC_LOAD4_CLR  = 8'h32;
    localparam logic [7:0] OPC_LOAD1_KEEP = 8'h84;
    localparam logic [7:0] OPC_LOAD4_KEEP = 8'h34;

    // Status bit positions, relative to the captured slice [5:2]
    localparam int ST_ERASE_FAIL = 0;
    localparam int ST_PROG_FAIL  = 1;
    localparam int ST_ECC_LO     = 2;

    typedef enum logic [2:0] {
        REQ_RESET     = 3'd0,
        REQ_READ_ID   = 3'd1,
        REQ_PAGE_READ = 3'd2,
        REQ_PROGRAM   = 3'd3,
        REQ_ERASE     = 3'd4
    } req_kind_e;

    typedef enum logic [3:0] {
        FR_RESET,
        FR_WREN,
        FR_READ_ID,
        FR_ARRAY_READ,
        FR_CACHE_READ,
        FR_CACHE_LOAD,
        FR_EXECUTE,
        FR_ERASE
    } frame_kind_e;

    typedef enum logic [1:0] {
        ACT_FRAME,
        ACT_WAIT,
        ACT_END
    } act_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_IN   = 2'd1,
        DIR_OUT  = 2'd2
    } dir_e;

    typedef struct packed {
        act_e        act;
        frame_kind_e frame;
    } step_t;

    typedef struct packed {
        logic [2:0]       kind;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             random_load;
        logic             quad;
        logic [1:0]       id_form;
    } req_hdr_t;

    typedef struct packed {
        logic [7:0]       opcode;
        logic [ROW_W-1:0] addr;
        logic [1:0]       addr_bytes;
        logic [1:0]       dummy_bytes;
        dir_e             dir;
        logic             quad;
    } frame_hdr_t;

    // Step list of each flow, indexed by position in the flow
    function automatic step_t flow_step(input logic [2:0] kind, input logic [2:0] idx);
        step_t s;
        s.act   = ACT_END;
        s.frame = FR_RESET;
        case (kind)
            REQ_RESET: begin
                if (idx == 3'd0) s = '{ACT_FRAME, FR_RESET};
                else if (idx == 3'd1) s.act = ACT_WAIT;
            end
            REQ_READ_ID: begin
                if (idx == 3'd0) s = '{ACT_FRAME, FR_READ_ID};
            end
            REQ_PAGE_READ: begin
                if (idx == 3'd0) s = '{ACT_FRAME, FR_ARRAY_READ};
                else if (idx == 3'd1) s.act = ACT_WAIT;
                else if (idx == 3'd2) s = '{ACT_FRAME, FR_CACHE_READ};
            end
            REQ_PROGRAM: begin
                if (idx == 3'd0) s = '{ACT_FRAME, FR_WREN};
                else if (idx == 3'd1) s = '{ACT_FRAME, FR_CACHE_LOAD};
                else if (idx == 3'd2) s = '{ACT_FRAME, FR_EXECUTE};
                else if (idx == 3'd3) s.act = ACT_WAIT;
            end
            REQ_ERASE: begin
                if (idx == 3'd0) s = '{ACT_FRAME, FR_WREN};
                else if (idx == 3'd1) s = '{ACT_FRAME, FR_ERASE};
                else if (idx == 3'd2) s.act = ACT_WAIT;
            end
            default: ;
        endcase
        return s;
    endfunction

    function automatic logic [7:0] load_opcode(input logic keep, input logic quad);
        logic [7:0] op;
        case ({keep, quad})
            2'b00:   op = OPC_LOAD1_CLR;
            2'b01:   op = OPC_LOAD4_CLR;
            2'b10:   op = OPC_LOAD1_KEEP;
            default: op = OPC_LOAD4_KEEP;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/nfs_frame_build.sv
module nfs_frame_build
    import nand_flow_pkg::*;
#(
    parameter int LEN_W    = 13,
    parameter int ID_BYTES = 4
) (
    input  frame_kind_e      fk,
    input  req_hdr_t         rq,
    input  logic [LEN_W-1:0] len,
    output frame_hdr_t       hdr,
    output logic [LEN_W-1:0] dlen
);

    localparam logic [LEN_W-1:0] ID_LEN = LEN_W'(ID_BYTES);

    always_comb begin
        hdr  = '0;
        dlen = '0;
        unique case (fk)
            FR_RESET: hdr.opcode = OPC_RESET;
            FR_WREN:  hdr.opcode = OPC_WREN;
            FR_READ_ID: begin
                hdr.opcode = OPC_READ_ID;
                hdr.dir    = DIR_IN;
                dlen       = ID_LEN;
                if (rq.id_form == 2'd1) hdr.addr_bytes  = 2'd1;
                if (rq.id_form == 2'd2) hdr.dummy_bytes = 2'd1;
            end
            FR_ARRAY_READ: begin
                hdr.opcode     = OPC_ARRAY_READ;
                hdr.addr       = rq.row;
                hdr.addr_bytes = 2'd3;
            end
            FR_CACHE_READ: begin
                hdr.opcode      = rq.quad ? OPC_CACHE_RD4 : OPC_CACHE_RD1;
                hdr.addr        = {{(ROW_W-COL_W){1'b0}}, rq.col};
                hdr.addr_bytes  = 2'd2;
                hdr.dummy_bytes = 2'd1;
                hdr.dir         = DIR_IN;
                hdr.quad        = rq.quad;
                dlen            = len;
            end
            FR_CACHE_LOAD: begin
                hdr.opcode     = load_opcode(rq.random_load, rq.quad);
                hdr.addr       = {{(ROW_W-COL_W){1'b0}}, rq.col};
                hdr.addr_bytes = 2'd2;
                hdr.dir        = DIR_OUT;
                hdr.quad       = rq.quad;
                dlen           = len;
            end
            FR_EXECUTE: begin
                hdr.opcode     = OPC_EXECUTE;
                hdr.addr       = rq.row;
                hdr.addr_bytes = 2'd3;
            end
            FR_ERASE: begin
                hdr.opcode     = OPC_ERASE;
                hdr.addr       = rq.row;
                hdr.addr_bytes = 2'd3;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nfs_id_capture.sv
module nfs_id_capture #(
    parameter int ID_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  enable,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    output logic [8*ID_BYTES-1:0] id_data
);

    localparam int PTR_W = $clog2(ID_BYTES + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(ID_BYTES);

    logic [PTR_W-1:0] ptr_q;
    logic             take;

    assign take = enable && rx_valid && (ptr_q < PTR_MAX);

    always_ff @(posedge clk) begin
        if (rst || clear) ptr_q <= '0;
        else if (take)    ptr_q <= ptr_q + 1'b1;
    end

    for (genvar b = 0; b < ID_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst || clear)
                id_data[b*8 +: 8] <= 8'h00;
            else if (take && ptr_q == PTR_W'(b))
                id_data[b*8 +: 8] <= rx_byte;
        end
    end

    assert_ptr_bound_R5: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= PTR_MAX);

    assert_no_capture_outside_R5: assert property (@(posedge clk) disable iff (rst)
        (!enable && !clear) |=> $stable(id_data));

endmodule

// File: rtl/nfs_flow_ctrl.sv
module nfs_flow_ctrl
    import nand_flow_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  req_hdr_t         req_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             frm_ready,
    input  logic             frm_done,
    input  logic             poll_done,
    input  logic [7:0]       poll_status,
    output req_hdr_t         rq,
    output logic [LEN_W-1:0] len_q,
    output frame_kind_e      frame_sel,
    output logic             busy,
    output logic             frm_valid,
    output logic             poll_req,
    output logic             id_clear,
    output logic             id_enable,
    output logic             done,
    output logic             done_fail,
    output logic [1:0]       done_ecc
);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_XFER} state_e;

    state_e      state_q;
    logic [2:0]  idx_q;
    logic [3:0]  stat_q;
    frame_kind_e cur_q;
    step_t       st;
    logic        accept;
    logic        end_fail;
    logic [1:0]  end_ecc;

    assign st        = flow_step(rq.kind, idx_q);
    assign frame_sel = st.frame;
    assign busy      = (state_q != S_IDLE);
    assign accept    = (state_q == S_IDLE) && req_valid;
    assign frm_valid = (state_q == S_RUN) && (st.act == ACT_FRAME);
    assign poll_req  = (state_q == S_RUN) && (st.act == ACT_WAIT);
    assign id_clear  = accept;
    assign id_enable = (state_q == S_XFER) && (cur_q == FR_READ_ID);

    always_comb begin
        end_ecc  = 2'b00;
        end_fail = 1'b0;
        case (rq.kind)
            REQ_RESET, REQ_READ_ID: end_fail = 1'b0;
            REQ_PAGE_READ: begin
                end_ecc  = stat_q[ST_ECC_LO +: 2];
                end_fail = (stat_q[ST_ECC_LO +: 2] == 2'b10);
            end
            REQ_PROGRAM: end_fail = stat_q[ST_PROG_FAIL];
            REQ_ERASE:   end_fail = stat_q[ST_ERASE_FAIL];
            default:     end_fail = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            idx_q     <= '0;
            stat_q    <= '0;
            cur_q     <= FR_RESET;
            rq        <= '0;
            len_q     <= '0;
            done      <= 1'b0;
            done_fail <= 1'b0;
            done_ecc  <= 2'b00;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        rq      <= req_in;
                        len_q   <= len_in;
                        idx_q   <= '0;
                        stat_q  <= '0;
                        state_q <= S_RUN;
                    end
                end
                S_RUN: begin
                    unique case (st.act)
                        ACT_FRAME: begin
                            if (frm_ready) begin
                                cur_q   <= st.frame;
                                state_q <= S_XFER;
                            end
                        end
                        ACT_WAIT: begin
                            if (poll_done) begin
                                stat_q <= poll_status[5:2];
                                idx_q  <= idx_q + 3'd1;
                            end
                        end
                        default: begin
                            done      <= 1'b1;
                            done_fail <= end_fail;
                            done_ecc  <= end_ecc;
                            state_q   <= S_IDLE;
                        end
                    endcase
                end
                S_XFER: begin
                    if (frm_done) begin
                        idx_q   <= idx_q + 3'd1;
                        state_q <= S_RUN;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assert_accept_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    assert_latch_held_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rq));

    assert_poll_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (poll_req && !poll_done) |=> poll_req);

    assert_frame_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ready) |=> frm_valid);

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/nand_flow_seq.sv
module nand_flow_seq
    import nand_flow_pkg::*;
#(
    parameter int LEN_W    = 13,
    parameter int ID_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [2:0]            req_kind,
    input  logic [23:0]           req_row,
    input  logic [15:0]           req_col,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_random_load,
    input  logic                  req_quad,
    input  logic [1:0]            req_id_form,
    output logic                  busy,
    output logic                  frm_valid,
    input  logic                  frm_ready,
    output logic [7:0]            frm_opcode,
    output logic [23:0]           frm_addr,
    output logic [1:0]            frm_addr_bytes,
    output logic [1:0]            frm_dummy_bytes,
    output logic [1:0]            frm_dir,
    output logic                  frm_quad,
    output logic [LEN_W-1:0]      frm_len,
    input  logic                  frm_done,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    output logic                  poll_req,
    input  logic                  poll_done,
    input  logic [7:0]            poll_status,
    output logic                  done,
    output logic                  done_fail,
    output logic [1:0]            done_ecc,
    output logic [8*ID_BYTES-1:0] id_data
);

    req_hdr_t         req_in;
    req_hdr_t         rq;
    logic [LEN_W-1:0] len_q;
    frame_kind_e      frame_sel;
    frame_hdr_t       hdr;
    logic             id_clear;
    logic             id_enable;

    always_comb begin
        req_in.kind        = req_kind;
        req_in.row         = req_row;
        req_in.col         = req_col;
        req_in.random_load = req_random_load;
        req_in.quad        = req_quad;
        req_in.id_form     = req_id_form;
    end

    nfs_flow_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_in      (req_in),
        .len_in      (req_len),
        .frm_ready   (frm_ready),
        .frm_done    (frm_done),
        .poll_done   (poll_done),
        .poll_status (poll_status),
        .rq          (rq),
        .len_q       (len_q),
        .frame_sel   (frame_sel),
        .busy        (busy),
        .frm_valid   (frm_valid),
        .poll_req    (poll_req),
        .id_clear    (id_clear),
        .id_enable   (id_enable),
        .done        (done),
        .done_fail   (done_fail),
        .done_ecc    (done_ecc)
    );

    nfs_frame_build #(.LEN_W(LEN_W), .ID_BYTES(ID_BYTES)) u_build (
        .fk   (frame_sel),
        .rq   (rq),
        .len  (len_q),
        .hdr  (hdr),
        .dlen (frm_len)
    );

    nfs_id_capture #(.ID_BYTES(ID_BYTES)) u_id (
        .clk      (clk),
        .rst      (rst),
        .clear    (id_clear),
        .enable   (id_enable),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .id_data  (id_data)
    );

    assign frm_opcode      = hdr.opcode;
    assign frm_addr        = hdr.addr;
    assign frm_addr_bytes  = hdr.addr_bytes;
    assign frm_dummy_bytes = hdr.dummy_bytes;
    assign frm_dir         = hdr.dir;
    assign frm_quad        = hdr.quad;

    assert_desc_stable_R12: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ready) |=> ($stable(frm_opcode) && $stable(frm_addr)
                                       && $stable(frm_len) && $stable(frm_dir)));

    assert_activity_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (frm_valid || poll_req) |-> busy);

    assert_done_idle_R13: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_one_channel_R12: assert property (@(posedge clk) disable iff (rst)
        !(frm_valid && poll_req));

endmodule

// File: tb/nand_flow_seq_test.sv
`timescale 1ns/1ps
module nand_flow_seq_test;

    localparam int LEN_W = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             req_valid = 1'b0;
    logic [2:0]       req_kind = '0;
    logic [23:0]      req_row = '0;
    logic [15:0]      req_col = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_random_load = 1'b0;
    logic             req_quad = 1'b0;
    logic [1:0]       req_id_form = '0;
    logic             busy, frm_valid, poll_req, done, done_fail, frm_quad;
    logic             frm_ready = 1'b0;
    logic             frm_done = 1'b0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = '0;
    logic             poll_done = 1'b0;
    logic [7:0]       poll_status = '0;
    logic [7:0]       frm_opcode;
    logic [23:0]      frm_addr;
    logic [1:0]       frm_addr_bytes, frm_dummy_bytes, frm_dir, done_ecc;
    logic [LEN_W-1:0] frm_len;
    logic [31:0]      id_data;

    nand_flow_seq #(.LEN_W(LEN_W), .ID_BYTES(4)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .req_random_load(req_random_load), .req_quad(req_quad),
        .req_id_form(req_id_form), .busy(busy), .frm_valid(frm_valid),
        .frm_ready(frm_ready), .frm_opcode(frm_opcode), .frm_addr(frm_addr),
        .frm_addr_bytes(frm_addr_bytes), .frm_dummy_bytes(frm_dummy_bytes),
        .frm_dir(frm_dir), .frm_quad(frm_quad), .frm_len(frm_len),
        .frm_done(frm_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .poll_req(poll_req), .poll_done(poll_done), .poll_status(poll_status),
        .done(done), .done_fail(done_fail), .done_ecc(done_ecc), .id_data(id_data)
    );

    int checks = 0;
    int errors = 0;

    logic [63:0] log_q[$];
    logic [63:0] exp_q[$];
    int          poll_count = 0;
    int          done_cycles = 0;
    bit          done_seen = 0;
    logic        got_fail = 1'b0;
    logic [1:0]  got_ecc = 2'b00;
    int          stall_cfg = 0;
    int          stall_left = 0;
    bit          ser_busy = 0;
    int          ser_cnt = 0;
    int          rx_left = 0;
    bit          rx_is_id = 0;
    int          rx_idx = 0;
    bit          pol_busy = 0;
    int          pol_cnt = 0;
    logic [7:0]  pol_cfg = 8'h00;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    function automatic logic [63:0] enc(input logic [7:0] op, input logic [23:0] a,
                                        input logic [1:0] ab, input logic [1:0] du,
                                        input logic [1:0] dr, input logic q,
                                        input logic [12:0] ln);
        return {12'd0, op, a, ab, du, dr, q, ln};
    endfunction

    function automatic logic [7:0] id_byte(input int i);
        case (i)
            0:       return 8'hC2;
            1:       return 8'h2C;
            2:       return 8'h15;
            default: return 8'h7A;
        endcase
    endfunction

    // Serializer, poller and per-clock checks, all acting at the falling edge
    always @(negedge clk) begin
        frm_ready = 1'b0;
        frm_done  = 1'b0;
        rx_valid  = 1'b0;
        poll_done = 1'b0;
        if (!rst) begin
            checks++;
            if (((frm_valid || poll_req) && !busy) || (frm_valid && poll_req) || (done && busy)) begin
                errors++;
                $display("FAIL R2/R13 per-clock: busy=%0b frm_valid=%0b poll_req=%0b done=%0b expected busy with activity, no overlap",
                         busy, frm_valid, poll_req, done);
            end
            if (done) begin
                done_seen = 1;
                done_cycles++;
                got_fail = done_fail;
                got_ecc  = done_ecc;
            end
            if (!ser_busy) begin
                if (frm_valid) begin
                    if (stall_left > 0) stall_left--;
                    else begin
                        frm_ready = 1'b1;
                        log_q.push_back(enc(frm_opcode, frm_addr, frm_addr_bytes,
                                            frm_dummy_bytes, frm_dir, frm_quad, frm_len));
                        ser_busy   = 1;
                        ser_cnt    = 2;
                        rx_is_id   = (frm_opcode == 8'h9F);
                        rx_idx     = 0;
                        rx_left    = (frm_dir == 2'd1) ? ((frm_len > 4) ? 4 : int'(frm_len)) : 0;
                        stall_left = stall_cfg;
                    end
                end
            end else if (rx_left > 0) begin
                rx_valid = 1'b1;
                rx_byte  = rx_is_id ? id_byte(rx_idx) : 8'hEE;
                rx_idx++;
                rx_left--;
            end else if (ser_cnt > 0) begin
                ser_cnt--;
            end else begin
                frm_done = 1'b1;
                ser_busy = 0;
            end
            if (!pol_busy && poll_req) begin
                pol_busy = 1;
                pol_cnt  = 2;
            end else if (pol_busy) begin
                if (pol_cnt > 0) pol_cnt--;
                else begin
                    poll_done   = 1'b1;
                    poll_status = pol_cfg;
                    pol_busy    = 0;
                    poll_count++;
                end
            end
        end
    end

    task automatic run(input logic [2:0] k, input logic [23:0] row, input logic [15:0] col,
                       input logic [12:0] ln, input bit rnd, input bit qd,
                       input logic [1:0] form, input logic [7:0] st,
                       input int exp_polls, input bit exp_fail, input logic [1:0] exp_ecc,
                       input string tag, input bit inject);
        int guard;
        log_q.delete();
        poll_count  = 0;
        done_seen   = 0;
        done_cycles = 0;
        pol_cfg     = st;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_row = row; req_col = col; req_len = ln;
        req_random_load = rnd; req_quad = qd; req_id_form = form;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, tag, "R2 busy after accept", busy, 1);
        if (inject) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_kind = 3'd4; req_row = 24'hFFFFFF; req_col = 16'hFFFF;
            @(negedge clk);
            req_valid = 1'b0;
        end
        guard = 0;
        while (!done_seen && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(done_seen, tag, "completion seen", done_seen, 1);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, tag, "R2 idle after completion", busy, 0);
        chk(done_cycles == 1, tag, "R13 done pulse width", done_cycles, 1);
        chk(log_q.size() == exp_q.size(), tag, "frame count", log_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
            chk(log_q[i] == exp_q[i], tag, $sformatf("frame %0d", i), log_q[i], exp_q[i]);
        chk(poll_count == exp_polls, tag, "wait-ready count", poll_count, exp_polls);
        chk(got_fail == exp_fail, tag, "fail flag", got_fail, exp_fail);
        chk(got_ecc == exp_ecc, tag, "ecc outcome", got_ecc, exp_ecc);
        exp_q.delete();
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1", "busy", busy, 0);
        chk(frm_valid === 1'b0, "R1", "frm_valid", frm_valid, 0);
        chk(poll_req === 1'b0, "R1", "poll_req", poll_req, 0);
        chk(done === 1'b0, "R1", "done", done, 0);

        // R3 reset flow
        exp_q.push_back(enc(8'hFF, 24'h0, 2'd0, 2'd0, 2'd0, 1'b0, 13'd0));
        run(3'd0, 24'h123456, 16'h0, 13'd0, 0, 0, 2'd0, 8'h00, 1, 0, 2'b00, "R3 reset", 0);

        // R4 R5 ID forms, with a stalled serializer on form 1 (R12)
        exp_q.push_back(enc(8'h9F, 24'h0, 2'd0, 2'd0, 2'd1, 1'b0, 13'd4));
        run(3'd1, 24'h0, 16'h0, 13'd0, 0, 0, 2'd0, 8'h00, 0, 0, 2'b00, "R4 id form0", 0);
        chk(id_data == 32'h7A152CC2, "R5", "id bytes form0", id_data, 32'h7A152CC2);
        stall_cfg = 3; stall_left = 3;
        exp_q.push_back(enc(8'h9F, 24'h0, 2'd1, 2'd0, 2'd1, 1'b0, 13'd4));
        run(3'd1, 24'hABCDEF, 16'h0, 13'd0, 0, 1, 2'd1, 8'h00, 0, 0, 2'b00, "R4 R12 id form1 stalled", 0);
        stall_cfg = 0; stall_left = 0;
        chk(id_data == 32'h7A152CC2, "R5", "id bytes form1", id_data, 32'h7A152CC2);
        exp_q.push_back(enc(8'h9F, 24'h0, 2'd0, 2'd1, 2'd1, 1'b0, 13'd4));
        run(3'd1, 24'h0, 16'h0, 13'd0, 0, 0, 2'd2, 8'h00, 0, 0, 2'b00, "R4 id form2", 0);
        exp_q.push_back(enc(8'h9F, 24'h0, 2'd0, 2'd0, 2'd1, 1'b0, 13'd4));
        run(3'd1, 24'h0, 16'h0, 13'd0, 0, 0, 2'd3, 8'h00, 0, 0, 2'b00, "R4 id form3", 0);

        // R6 R7 page reads; the cache read returns bytes that must not reach id_data (R5)
        exp_q.push_back(enc(8'h13, 24'h01A2B3, 2'd3, 2'd0, 2'd0, 1'b0, 13'd0));
        exp_q.push_back(enc(8'h0B, 24'h000123, 2'd2, 2'd1, 2'd1, 1'b0, 13'd64));
        run(3'd2, 24'h01A2B3, 16'h0123, 13'd64, 0, 0, 2'd0, 8'h10, 1, 0, 2'b01, "R6 R7 read single", 0);
        chk(id_data == 32'h0, "R5", "id cleared, not loaded by cache read", id_data, 0);
        stall_cfg = 2; stall_left = 2;
        exp_q.push_back(enc(8'h13, 24'h7F0001, 2'd3, 2'd0, 2'd0, 1'b0, 13'd0));
        exp_q.push_back(enc(8'h6B, 24'h000800, 2'd2, 2'd1, 2'd1, 1'b1, 13'd2112));
        run(3'd2, 24'h7F0001, 16'h0800, 13'd2112, 0, 1, 2'd0, 8'h20, 1, 1, 2'b10, "R6 R7 read quad uncorrectable", 0);
        stall_cfg = 0; stall_left = 0;
        exp_q.push_back(enc(8'h13, 24'h000002, 2'd3, 2'd0, 2'd0, 1'b0, 13'd0));
        exp_q.push_back(enc(8'h0B, 24'h000000, 2'd2, 2'd1, 2'd1, 1'b0, 13'd1));
        run(3'd2, 24'h000002, 16'h0000, 13'd1, 0, 0, 2'd0, 8'h3C, 1, 0, 2'b11, "R7 read ecc 3 not fail", 0);

        // R8 R9 R10 programs, all four load forms
        for (int m = 0; m < 4; m++) begin
            logic [7:0] lop;
            lop = (m == 0) ? 8'h02 : (m == 1) ? 8'h32 : (m == 2) ? 8'h84 : 8'h34;
            exp_q.push_back(enc(8'h06, 24'h0, 2'd0, 2'd0, 2'd0, 1'b0, 13'd0));
            exp_q.push_back(enc(lop, 24'h000040, 2'd2, 2'd0, 2'd2, m[0], 13'd16));
            exp_q.push_back(enc(8'h10, 24'h00C0DE, 2'd3, 2'd0, 2'd0, 1'b0, 13'd0));
            run(3'd3, 24'h00C0DE, 16'h0040, 13'd16, m[1], m[0], 2'd0, 8'h34, 1, 0, 2'b00,
                $sformatf("R8 R9 R10 R7 program load form %0d", m), 0);
        end
        exp_q.push_back(enc(8'h06, 24'h0, 2'd0, 2'd0, 2'd0, 1'b0, 13'd0));
        exp_q.push_back(enc(8'h02, 24'h000010, 2'd2, 2'd0, 2'd2, 1'b0, 13'd8));
        exp_q.push_back(enc(8'h10, 24'h123456, 2'd3, 2'd0, 2'd0, 1'b0, 13'd0));
        run(3'd3, 24'h123456, 16'h0010, 13'd8, 0, 0, 2'd0, 8'h08, 1, 1, 2'b00, "R10 program fail", 0);

        // R2 request injected while busy is ignored
        exp_q.push_back(enc(8'h06, 24'h0, 2'd0, 2'd0, 2'd0, 1'b0, 13'd0));
        exp_q.push_back(enc(8'h84, 24'h000321, 2'd2, 2'd0, 2'd2, 1'b0, 13'd32));
        exp_q.push_back(enc(8'h10, 24'h0A0B0C, 2'd3, 2'd0, 2'd0, 1'b0, 13'd0));
        run(3'd3, 24'h0A0B0C, 16'h0321, 13'd32, 1, 0, 2'd0, 8'h00, 1, 0, 2'b00, "R2 busy injection", 1);
        repeat (10) @(negedge clk);
        chk(log_q.size() == 3, "R2", "no frames after injected request", log_q.size(), 3);

        // R11 erase
        exp_q.push_back(enc(8'h06, 24'h0, 2'd0, 2'd0, 2'd0, 1'b0, 13'd0));
        exp_q.push_back(enc(8'hD8, 24'h004000, 2'd3, 2'd0, 2'd0, 1'b0, 13'd0));
        run(3'd4, 24'h004000, 16'h0, 13'd0, 0, 0, 2'd0, 8'h04, 1, 1, 2'b00, "R11 erase fail", 0);
        exp_q.push_back(enc(8'h06, 24'h0, 2'd0, 2'd0, 2'd0, 1'b0, 13'd0));
        exp_q.push_back(enc(8'hD8, 24'hFFFFC0, 2'd3, 2'd0, 2'd0, 1'b0, 13'd0));
        run(3'd4, 24'hFFFFC0, 16'h0, 13'd0, 0, 0, 2'd0, 8'h38, 1, 0, 2'b00, "R11 R7 erase pass", 0);

        // R14 unknown kinds
        run(3'd5, 24'h0, 16'h0, 13'd4, 0, 0, 2'd0, 8'h00, 0, 1, 2'b00, "R14 kind 5", 0);
        run(3'd7, 24'h1, 16'h1, 13'd4, 1, 1, 2'd1, 8'h00, 0, 1, 2'b00, "R14 kind 7", 0);

        summary();
        $finish;
    end

endmodule